// File: doc/BRIEF.md
# Buffered Prescaler Timer Time Base

This block is a 16-bit up-counting time base. An input clock is divided by a programmable prescaler, and each divided tick advances a counter that wraps at a programmable limit. When the counter wraps, an update event fires. An update event also fires when software writes a strobe, or when an external trigger clears the counter. The prescaler value that software writes does not act at once. It is held in a staging register and copied into the active divider only on an update event, so a new rate always starts on a clean period boundary.

Software reaches the block through a plain register port: one write-enable, an address, write data, and combinational read data. Every update event sets a sticky interrupt flag, which software clears by writing zero. The counter readback can optionally show that flag in its top bit, so a single read returns both the count and whether a wrap has happened.

Top module: `presc_timebase`

## Requirements
- R1: After reset the staged prescaler (address 4) reads 0x0000, the limit (address 5) reads 0x0000FFFF, the counter (address 3) reads 0, the flag (address 1, bit 0) reads 0 and the remap control (address 0, bit 0) reads 0.
- R2: With an active prescaler value P and a nonzero limit, the counter advances by one every P+1 clocks; with P=0 it advances every clock.
- R3: A write to the staged prescaler (address 4, bits 15:0) leaves the division rate unchanged until the next update event, which copies the staged value into the active divider.
- R4: When the counter equals a nonzero limit on a divided tick, it returns to 0 on that tick, update_o pulses high for one cycle, and the flag is set.
- R5: Writing 1 to bit 0 of address 2 is a software update: the counter and the divider phase clear to 0, the active prescaler loads, update_o pulses and the flag is set.
- R6: A high cycle on trig_reset_i has the same effect as the software update of R5.
- R7: While the limit is 0, the counter holds its value. A software update or a trigger still clears it.
- R8: Writing 0 to bit 0 of address 1 clears the flag. If an update event happens in the same cycle, the flag stays set.
- R9: Reading address 3 returns the counter in bits 15:0 and zeros in bits 30:16. Bit 31 holds the flag when remap (address 0, bit 0) is 1, and 0 when remap is 0.
- R10: The limit register (address 5) has no staging; a new value is used from the next clock's comparison onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Combinational read data for reg_addr_i |
| trig_reset_i | input | 1 | External reset-mode trigger, active high |
| cnt_o | output | 16 | Current counter value |
| uflag_o | output | 1 | Update interrupt flag |
| update_o | output | 1 | One-cycle pulse in the cycle after an update event |

## Verification
The counter is first run at prescale 0 with the full 16-bit limit. This shows per-clock stepping apart from any wrap. A short limit then separates the wrap point from an off-by-one compare. A staged prescale of 2 is written mid-count, and the bench checks that stepping stays at one per clock until a software update, then changes to one per three clocks. This separates staged loading from immediate loading. The trigger input, a flag clear that coincides with an event, and a zero limit each test one priority or freeze rule. With remap on and off, the readback shows whether bit 31 follows the flag or is forced to zero.

// File: rtl/ptb_pkg.sv
package ptb_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_STAT  = 3'd1,
    A_EVGEN = 3'd2,
    A_CNT   = 3'd3,
    A_PSC   = 3'd4,
    A_ARR   = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/ptb_regs.sv
module ptb_regs
  import ptb_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          upd_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] psc_o,
  output logic [CW-1:0] arr_o,
  output logic          remap_o,
  output logic          flag_o,
  output logic          ug_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned PAD_W = DW - CW - 1;
  localparam logic [CW-1:0] ARR_RST = {CW{1'b1}};

  logic wr_ctrl, wr_stat, wr_psc, wr_arr;
  logic [CW-1:0] psc_q, arr_q;
  logic remap_q, flag_q;

  assign wr_ctrl = we_i && (addr_i == A_CTRL);
  assign wr_stat = we_i && (addr_i == A_STAT);
  assign wr_psc  = we_i && (addr_i == A_PSC);
  assign wr_arr  = we_i && (addr_i == A_ARR);
  assign ug_o    = we_i && (addr_i == A_EVGEN) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q   <= '0;
      arr_q   <= ARR_RST;
      remap_q <= 1'b0;
    end else begin
      if (wr_psc)  psc_q   <= wdata_i[CW-1:0];
      if (wr_arr)  arr_q   <= wdata_i[CW-1:0];
      if (wr_ctrl) remap_q <= wdata_i[0];
    end
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      flag_q <= 1'b0;
    else if (upd_i)                   flag_q <= 1'b1;
    else if (wr_stat && !wdata_i[0])  flag_q <= 1'b0;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o[0] = remap_q;
      A_STAT:  rdata_o[0] = flag_q;
      A_CNT:   rdata_o = {remap_q & flag_q, {PAD_W{1'b0}}, cnt_i};
      A_PSC:   rdata_o[CW-1:0] = psc_q;
      A_ARR:   rdata_o[CW-1:0] = arr_q;
      default: rdata_o = '0;
    endcase
  end

  assign psc_o   = psc_q;
  assign arr_o   = arr_q;
  assign remap_o = remap_q;
  assign flag_o  = flag_q;

  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> flag_q);
  p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_stat && !wdata_i[0] && !upd_i) |=> !flag_q);
  p_bit31_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_CNT && !remap_q) |-> (rdata_o[DW-1:CW] == '0));
endmodule

// File: rtl/ptb_prescaler.sv
module ptb_prescaler #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] psc_i,
  input  logic          upd_i,
  output logic          tick_o
);
  logic [CW-1:0] act_q, div_q;

  assign tick_o = (div_q == act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      div_q <= '0;
    end else begin
      if (upd_i) act_q <= psc_i;
      if (upd_i || tick_o) div_q <= '0;
      else                 div_q <= div_q + CW'(1);
    end
  end

  p_act_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_i |=> $stable(act_q));
  p_act_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (act_q == $past(psc_i)));
  p_div_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (div_q == '0));
endmodule

// File: rtl/ptb_counter.sv
module ptb_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [CW-1:0] arr_i,
  output logic [CW-1:0] cnt_o,
  output logic          ovf_o
);
  logic [CW-1:0] cnt_q;
  logic run;

  assign run   = tick_i && (arr_i != '0);
  assign ovf_o = run && (cnt_q == arr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (ovf_o)  cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + CW'(1);
  end

  assign cnt_o = cnt_q;

  p_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arr_i == '0 && !clr_i) |=> $stable(cnt_q));
  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && arr_i != '0 && cnt_q == arr_i) |=> (cnt_q == '0));
  p_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && arr_i != '0 && cnt_q != arr_i && !clr_i) |=> (cnt_q == $past(cnt_q) + CW'(1)));
endmodule

// File: rtl/presc_timebase.sv
module presc_timebase
  import ptb_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          trig_reset_i,
  output logic [CW-1:0] cnt_o,
  output logic          uflag_o,
  output logic          update_o
);
  logic [CW-1:0] psc, arr, cnt;
  logic remap, ug, tick, ovf, clr, upd, update_q;

  assign clr = ug | trig_reset_i;
  assign upd = clr | ovf;

  ptb_regs #(.CW(CW), .DW(DW), .AW(AW)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .upd_i   (upd),
    .cnt_i   (cnt),
    .psc_o   (psc),
    .arr_o   (arr),
    .remap_o (remap),
    .flag_o  (uflag_o),
    .ug_o    (ug),
    .rdata_o (reg_rdata_o)
  );

  ptb_prescaler #(.CW(CW)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .psc_i  (psc),
    .upd_i  (upd),
    .tick_o (tick)
  );

  ptb_counter #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .clr_i  (clr),
    .arr_i  (arr),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) update_q <= 1'b0;
    else         update_q <= upd;
  end

  assign cnt_o    = cnt;
  assign update_o = update_q;

  p_trig_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_reset_i |=> (cnt_o == '0 && update_o && uflag_o));
  p_ug_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug |=> (cnt_o == '0 && update_o));
  p_remap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == A_CNT && remap) |-> (reg_rdata_o[DW-1] == uflag_o));
endmodule

// File: tb/tb_presc_timebase.sv
module tb_presc_timebase;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic [2:0] addr = 3'd3;
  logic [31:0] wdata = '0;
  logic trig = 1'b0;
  logic [31:0] rdata;
  logic [15:0] cnt;
  logic uflag, update;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  presc_timebase dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trig_reset_i(trig),
    .cnt_o(cnt), .uflag_o(uflag), .update_o(update)
  );

  // behavioural reference
  int m_cnt = 0, m_div = 0, m_act = 0, m_psc = 0, m_arr = 65535;
  bit m_flag = 0, m_remap = 0, m_upd = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit tk, sw, ov, ev;
      int n_cnt, n_div, n_act;
      bit n_flag;
      tk = (m_div == m_act);
      sw = we && addr == 3'd2 && wdata[0];
      ov = tk && m_arr != 0 && m_cnt == m_arr;
      ev = sw || trig || ov;
      if (sw || trig) n_cnt = 0;
      else if (ov) n_cnt = 0;
      else if (tk && m_arr != 0) n_cnt = (m_cnt + 1) % 65536;
      else n_cnt = m_cnt;
      n_div = (ev || tk) ? 0 : m_div + 1;
      n_act = ev ? m_psc : m_act;
      if (ev) n_flag = 1;
      else if (we && addr == 3'd1 && !wdata[0]) n_flag = 0;
      else n_flag = m_flag;
      if (we && addr == 3'd4) m_psc = int'(wdata[15:0]);
      if (we && addr == 3'd5) m_arr = int'(wdata[15:0]);
      if (we && addr == 3'd0) m_remap = wdata[0];
      m_cnt = n_cnt; m_div = n_div; m_act = n_act; m_flag = n_flag; m_upd = ev;
    end
  end

  function automatic logic [31:0] exp_rd(input logic [2:0] a);
    case (a)
      3'd0: return {31'd0, m_remap};
      3'd1: return {31'd0, m_flag};
      3'd3: return {m_remap & m_flag, 15'd0, 16'(m_cnt)};
      3'd4: return {16'd0, 16'(m_psc)};
      3'd5: return {16'd0, 16'(m_arr)};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model, mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2/R4/R7 cnt", cnt, m_cnt);
      chk("R4/R8 flag", uflag, m_flag);
      chk("R4/R5 update", update, m_upd);
      chk("R9/R1 rdata", rdata, exp_rd(addr));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 1'b0; addr = 3'd3;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    addr = a; #1;
    chk(tag, rdata, e);
    addr = 3'd3;
  endtask

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] c0;
    #12; rst_n = 1'b1;
    @(posedge clk); #1;
    // R1 reset state (one clock at psc 0 has passed)
    rd_chk(3'd4, 32'h0, "R1 psc");
    rd_chk(3'd5, 32'h0000FFFF, "R1 arr");
    rd_chk(3'd1, 32'h0, "R1 flag");
    rd_chk(3'd0, 32'h0, "R1 remap");
    // R2 every clock at psc 0
    c0 = cnt; clocks(10);
    chk("R2 step psc0", cnt, c0 + 10);
    // R4 + R10 wrap at limit 5
    wr(3'd5, 32'd5);
    wr(3'd2, 32'd1);
    wr(3'd1, 32'd0);
    clocks(4);
    chk("R4 before wrap", cnt, 5);
    chk("R8 cleared", uflag, 0);
    clocks(1);
    chk("R4 wrap cnt", cnt, 0);
    chk("R4 wrap update", update, 1);
    chk("R4 wrap flag", uflag, 1);
    // R10 raise limit
    wr(3'd5, 32'd1000);
    // R3 staged prescaler
    wr(3'd2, 32'd1);
    wr(3'd4, 32'd2);
    c0 = cnt; clocks(4);
    chk("R3 rate unchanged", cnt, c0 + 4);
    // R5 software update loads prescaler
    wr(3'd2, 32'd1);
    chk("R5 cnt clear", cnt, 0);
    chk("R5 update", update, 1);
    clocks(8);
    chk("R2 psc2 at 8", cnt, 2);
    clocks(1);
    chk("R2 psc2 at 9", cnt, 3);
    // R6 trigger
    wr(3'd1, 32'd0);
    clocks(2);
    trig = 1'b1; @(posedge clk); #1; trig = 1'b0;
    chk("R6 cnt clear", cnt, 0);
    chk("R6 flag", uflag, 1);
    chk("R6 update", update, 1);
    // R8 set wins over clear
    trig = 1'b1; we = 1'b1; addr = 3'd1; wdata = 32'd0;
    @(posedge clk); #1;
    trig = 1'b0; we = 1'b0; addr = 3'd3;
    chk("R8 set wins", uflag, 1);
    // R9 remap
    rd_chk(3'd3, {16'd0, cnt}, "R9 remap off");
    wr(3'd0, 32'd1);
    rd_chk(3'd3, {1'b1, 15'd0, cnt}, "R9 remap on flag");
    wr(3'd1, 32'd0);
    rd_chk(3'd3, {16'd0, cnt}, "R9 remap on cleared");
    // R7 zero limit freezes
    wr(3'd4, 32'd0);
    wr(3'd2, 32'd1);
    clocks(3);
    wr(3'd5, 32'd0);
    c0 = cnt; clocks(10);
    chk("R7 frozen", cnt, c0);
    wr(3'd2, 32'd1);
    chk("R7 clear while frozen", cnt, 0);
    clocks(5);
    chk("R7 still frozen", cnt, 0);
    wr(3'd5, 32'd3);
    clocks(5);
    chk("R10 resumes", cnt, 1);
    clocks(20);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule